// File: doc/BRIEF.md
# Looping Fractional-Integral Sample Player

This block is a sample player for a digital emulator. It plays back stored waveforms at a fixed sample rate. A bank holds several constant tables. Each table stores the steady-state fractional integral of a sine input for one pairing of fractional order and excitation frequency. A select input picks the active table. An internal clock-enable divider produces the sample strobe. With the default divide of 200 and a 200 MHz clock, the strobe runs at 1 MHz whatever the waveform frequency, so a 7 kHz setting spans about 143 samples per period.

A table usually holds several waveform periods. The first period carries the start-up transient and is played once. After the last stored sample, the read pointer jumps back to a loop-start address set per table, so playback repeats only the stable periods. Each table has its own length and its own loop-start address. When the effective selection changes, playback restarts at address zero of the new table, so the transient replays. Every new sample is flagged by a one-clock valid pulse.

Top module: `wt_player`

## Requirements
- R1: While `rst` is high, `valid` is low and `sample` is zero from the first clock edge onward.
- R2: `valid` is high for exactly one clock once every `STROBE_DIV` clocks. The first pulse follows the `STROBE_DIV`-th rising edge after reset is released. `valid` is never high at any other time.
- R3: On each strobe without a selection change, the word at the current address of the current table is output, and the pointer moves to the next address.
- R4: Each table `t` has its own length `TBL_LEN[t]` and loop-start address `LOOP_AT[t]`, with `LOOP_AT[t] < TBL_LEN[t]`. Both are checked at elaboration.
- R5: After the word at address `TBL_LEN[t]-1` is output, the next strobe outputs address `LOOP_AT[t]`, not address zero.
- R6: When the effective selection differs from the one used at the previous strobe, the next strobe outputs address 0 of the newly selected table. Addresses then continue from 1.
- R7: Between valid pulses, `sample` holds its last value.
- R8: A select value of `NUM_TABLES` or above selects table `NUM_TABLES-1`. Moving between two select values that map to the same table is not a change.
- R9: If a selection change lands on the same strobe that would wrap the old table, the restart at address 0 of the new table takes precedence.
- R10: With the default contents, bits [39:32] of each word hold the table index and bits [31:0] hold the address within the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (200 MHz target) |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | SEL_W | Order/frequency table select |
| sample | output | SAMPLE_W | Signed sample word of the active table |
| valid | output | 1 | One-clock pulse marking a new sample |

## Verification
Two events can fall on the same strobe: a selection change and the wrap back to the loop-start address. To provoke this, the bench waits until its model shows the pointer on the last address of the current table. It then changes `sel` before the next strobe, once toward an in-range table and once toward an out-of-range value. The bench expects address 0 of the new table (R9), not the old table's loop-start word. It also checks that moving from an out-of-range value to the table it maps to does not restart playback.

// File: rtl/wt_pkg.sv
package wt_pkg;

   typedef enum logic [1:0] {
      WT_STEP    = 2'd0,
      WT_WRAP    = 2'd1,
      WT_RESTART = 2'd2
   } wt_step_e;

   function automatic int unsigned wt_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wt_strobe_gen.sv
module wt_strobe_gen #(
   parameter int unsigned DIV = 200
) (
   input  logic clk,
   input  logic rst,
   output logic stb
);
   localparam int unsigned CW = wt_pkg::wt_bits(DIV);

   if (DIV < 2) begin : g_bad_div
      $error("wt_strobe_gen: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign stb = (cnt_q == CW'(DIV - 1));

   always_ff @(posedge clk) begin
      if (rst)      cnt_q <= '0;
      else if (stb) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
   end

   AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
      stb |=> !stb);  // R2

endmodule

// File: rtl/wt_addr_seq.sv
module wt_addr_seq
   import wt_pkg::*;
#(
   parameter int unsigned N      = 5,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned TBL_LEN [N] = '{24, 30, 16, 40, 12},
   parameter int unsigned LOOP_AT [N] = '{6, 10, 4, 8, 3}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stb,
   input  logic [SEL_W-1:0]  sel_in,
   output logic [SEL_W-1:0]  rd_sel,
   output logic [ADDR_W-1:0] rd_addr,
   output wt_step_e          step
);
   logic [ADDR_W-1:0] last_addr [N];
   logic [ADDR_W-1:0] loop_addr [N];

   for (genvar t = 0; t < N; t++) begin : g_desc
      assign last_addr[t] = ADDR_W'(TBL_LEN[t] - 1);
      assign loop_addr[t] = ADDR_W'(LOOP_AT[t]);
   end

   logic [SEL_W-1:0]  eff_sel, last_q;
   logic [ADDR_W-1:0] ptr_q, nxt;
   logic              chg, at_end;

   // out-of-range selects fold onto the last table
   assign eff_sel = ({1'b0, sel_in} >= (SEL_W+1)'(N)) ? SEL_W'(N - 1) : sel_in;
   assign chg     = (eff_sel != last_q);
   assign rd_addr = chg ? '0 : ptr_q;
   assign at_end  = (rd_addr == last_addr[eff_sel]);
   assign nxt     = at_end ? loop_addr[eff_sel] : rd_addr + 1'b1;
   assign rd_sel  = eff_sel;

   always_comb begin
      if (chg)         step = WT_RESTART;
      else if (at_end) step = WT_WRAP;
      else             step = WT_STEP;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q  <= '0;
         last_q <= '0;
      end else if (stb) begin
         ptr_q  <= nxt;
         last_q <= eff_sel;
      end
   end

   AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
      ptr_q <= last_addr[last_q]);  // R4

   AST_WRAP_TO_LOOP: assert property (@(posedge clk) disable iff (rst)
      (stb && step == WT_WRAP) |=> ptr_q == $past(loop_addr[eff_sel]));  // R5

   AST_RESTART_TAKES: assert property (@(posedge clk) disable iff (rst)
      (stb && step == WT_RESTART) |=> last_q == $past(eff_sel));  // R6

   AST_PTR_QUIET: assert property (@(posedge clk) disable iff (rst)
      !stb |=> ($stable(ptr_q) && $stable(last_q)));  // R3

endmodule

// File: rtl/wt_table_bank.sv
module wt_table_bank #(
   parameter int unsigned N      = 5,
   parameter int unsigned W      = 40,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned TBL_LEN [N] = '{24, 30, 16, 40, 12}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stb,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [W-1:0]      word
);
   // default contents: table index in the top byte, address in bits 31:0
   function automatic logic [W-1:0] fill_word(input int unsigned t, input int unsigned a);
      logic [W-1:0] v;
      v = '0;
      v[W-1 -: 8] = 8'(t);
      v[31:0]     = 32'(a);
      return v;
   endfunction

   logic [W-1:0]     tbl_w [N];
   logic [SEL_W-1:0] sel_q;

   for (genvar t = 0; t < N; t++) begin : g_tbl
      localparam int unsigned AW_T = wt_pkg::wt_bits(TBL_LEN[t]);
      logic [W-1:0] mem [TBL_LEN[t]];
      logic [W-1:0] q;

      initial begin
         for (int i = 0; i < int'(TBL_LEN[t]); i++) mem[i] = fill_word(t, i);
      end

      always_ff @(posedge clk) begin
         if (rst)
            q <= '0;
         else if (stb)
            q <= ({1'b0, rd_addr} < (ADDR_W+1)'(TBL_LEN[t])) ? mem[rd_addr[AW_T-1:0]] : '0;
      end

      assign tbl_w[t] = q;
   end

   always_ff @(posedge clk) begin
      if (rst)      sel_q <= '0;
      else if (stb) sel_q <= rd_sel;
   end

   assign word = tbl_w[sel_q];

   AST_SEL_IN_BANK: assert property (@(posedge clk) disable iff (rst)
      stb |-> ({1'b0, rd_sel} < (SEL_W+1)'(N)));  // R8

endmodule

// File: rtl/wt_player.sv
module wt_player
   import wt_pkg::*;
#(
   parameter int unsigned NUM_TABLES = 5,
   parameter int unsigned SAMPLE_W   = 40,
   parameter int unsigned STROBE_DIV = 200,
   parameter int unsigned TBL_LEN [NUM_TABLES] = '{24, 30, 16, 40, 12},
   parameter int unsigned LOOP_AT [NUM_TABLES] = '{6, 10, 4, 8, 3},
   localparam int unsigned SEL_W = wt_pkg::wt_bits(NUM_TABLES)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [SEL_W-1:0]           sel,
   output logic signed [SAMPLE_W-1:0] sample,
   output logic                       valid
);
   function automatic int unsigned longest();
      int unsigned m = 1;
      for (int t = 0; t < int'(NUM_TABLES); t++)
         if (TBL_LEN[t] > m) m = TBL_LEN[t];
      return m;
   endfunction

   localparam int unsigned MAX_LEN = longest();
   localparam int unsigned ADDR_W  = wt_pkg::wt_bits(MAX_LEN);

   if (SAMPLE_W < 40) begin : g_bad_w
      $error("wt_player: SAMPLE_W must hold index byte and 32-bit address");
   end
   if (NUM_TABLES < 1 || NUM_TABLES > 256) begin : g_bad_n
      $error("wt_player: NUM_TABLES out of range");
   end
   for (genvar t = 0; t < NUM_TABLES; t++) begin : g_chk
      if (TBL_LEN[t] < 1 || LOOP_AT[t] >= TBL_LEN[t]) begin : g_bad_desc
         $error("wt_player: loop start must lie inside its table");  // R4
      end
   end

   logic              stb;
   logic [SEL_W-1:0]  rd_sel;
   logic [ADDR_W-1:0] rd_addr;
   wt_step_e          step;
   logic [SAMPLE_W-1:0] word;
   logic              valid_q;

   wt_strobe_gen #(.DIV(STROBE_DIV)) u_stb (
      .clk (clk),
      .rst (rst),
      .stb (stb)
   );

   wt_addr_seq #(
      .N(NUM_TABLES), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
      .TBL_LEN(TBL_LEN), .LOOP_AT(LOOP_AT)
   ) u_seq (
      .clk     (clk),
      .rst     (rst),
      .stb     (stb),
      .sel_in  (sel),
      .rd_sel  (rd_sel),
      .rd_addr (rd_addr),
      .step    (step)
   );

   wt_table_bank #(
      .N(NUM_TABLES), .W(SAMPLE_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
      .TBL_LEN(TBL_LEN)
   ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .stb     (stb),
      .rd_sel  (rd_sel),
      .rd_addr (rd_addr),
      .word    (word)
   );

   always_ff @(posedge clk) begin
      if (rst) valid_q <= 1'b0;
      else     valid_q <= stb;
   end

   assign valid  = valid_q;
   assign sample = word;

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      valid |=> !valid);  // R2

   AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !valid |-> $stable(sample));  // R7

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
      (stb && step == WT_RESTART) |=> sample[31:0] == 32'd0);  // R9

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> (!valid && sample == '0));  // R1

endmodule

// File: tb/tb_wt_player.sv
`timescale 1ns/1ps
module tb_wt_player;
   localparam int N   = 5;
   localparam int W   = 40;
   localparam int DIV = 8;
   localparam int unsigned LENS  [N] = '{24, 30, 16, 40, 12};
   localparam int unsigned LOOPS [N] = '{6, 10, 4, 8, 3};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2:0] sel = 3'd0;
   logic signed [W-1:0] sample;
   logic valid;

   wt_player #(
      .NUM_TABLES(N), .SAMPLE_W(W), .STROBE_DIV(DIV),
      .TBL_LEN(LENS), .LOOP_AT(LOOPS)
   ) dut (
      .clk(clk), .rst(rst), .sel(sel), .sample(sample), .valid(valid)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit started = 0, done = 0;

   // reference model state
   int m_cnt = 0, m_ptr = 0, m_last = 0;
   logic [W-1:0] m_sample = '0;
   logic m_valid = 1'b0;
   string m_tag = "R1";

   function automatic logic [W-1:0] ref_word(input int t, input int a);
      return {8'(t), 32'(a)};  // R10 layout
   endfunction

   always @(posedge clk) begin
      started = 1;
      if (rst) begin
         m_cnt = 0; m_ptr = 0; m_last = 0;
         m_sample = '0; m_valid = 1'b0; m_tag = "R1";
      end else begin
         bit s;
         int es, a;
         bit ch, old_end;
         s = (m_cnt == DIV - 1);
         m_cnt = s ? 0 : m_cnt + 1;
         m_valid = s;
         if (s) begin
            es = (int'(sel) >= N) ? N - 1 : int'(sel);
            ch = (es != m_last);
            old_end = (m_ptr == int'(LENS[m_last]) - 1);
            a = ch ? 0 : m_ptr;
            m_sample = ref_word(es, a);
            if (ch && old_end)                   m_tag = "R9";
            else if (ch)                         m_tag = "R6";
            else if (a == int'(LENS[es]) - 1)    m_tag = "R5";
            else if (int'(sel) >= N)             m_tag = "R8";
            else                                 m_tag = "R3 R10";
            m_ptr = (a == int'(LENS[es]) - 1) ? int'(LOOPS[es]) : a + 1;
            m_last = es;
         end else begin
            m_tag = "R7";
         end
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         n_chk++;
         if (valid !== m_valid) begin
            n_fail++;
            $display("FAIL %s valid: actual %b expected %b at %0t",
                     rst ? "R1" : "R2", valid, m_valid, $time);
         end
         n_chk++;
         if (sample !== m_sample) begin
            n_fail++;
            $display("FAIL %s sample: actual %h expected %h at %0t",
                     m_tag, sample, m_sample, $time);
         end
      end
   end

   task automatic run_strobes(input int n);
      repeat (n * DIV) @(negedge clk);
   endtask

   task automatic wait_last_addr();
      for (int i = 0; i < 100 * DIV; i++) begin
         @(negedge clk);
         if (m_ptr == int'(LENS[m_last]) - 1) break;
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      sel = 3'd0; run_strobes(40);           // R3, R5 on table 0
      sel = 3'd3; run_strobes(50);           // R6 restart, R5 on table 3
      sel = 3'd7; run_strobes(15);           // R8 fold onto table 4
      sel = 3'd4; run_strobes(5);            // R8 same table: no restart
      sel = 3'd1; run_strobes(3);
      wait_last_addr(); sel = 3'd2;          // R9 change on wrap strobe
      run_strobes(20);
      wait_last_addr(); sel = 3'd6;          // R9 with folded select
      run_strobes(10);
      rst = 1'b1; repeat (3) @(negedge clk); // R1 mid-run reset
      rst = 1'b0; run_strobes(10);
      finish_run();
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

endmodule